// File: doc/BRIEF.md
# Precise Trap Flush Controller

This block turns faults raised inside a five-stage in-order pipeline into precise traps. The decode, execute and memory stages each have a fault request line, a fault code and their own PC. In the cycle a fault is seen, the block picks the oldest faulting instruction, which is the one furthest down the pipe. It squashes that instruction and everything younger by clearing the control fields of the pipeline registers. Instructions older than the fault are left to retire.

The faulting PC goes into an exception-PC register and its code into a cause register. One cycle later the block redirects fetch to a fixed handler address.

An external interrupt is handled differently. Fetch is frozen and the instruction waiting in fetch is kept out of decode. The block waits until the datapath reports that no older instruction is still in flight. It then saves the frozen fetch PC as the return address, records the interrupt cause and redirects fetch to the same handler.

Top module: `trap_flush_ctrl`

## Requirements
- R1: While reset is held, every flush bit, fetch_hold and redirect are 0, and epc and cause read 0.
- R2: When several stages request a fault in one cycle, the oldest one is recorded: memory beats execute, and execute beats decode. Request bit 0 is decode, bit 1 is execute and bit 2 is memory. epc takes the PC of the winning stage.
- R3: In the fault cycle, the flush bits squash the winner and every younger instruction. Flush bit 0 clears IF/ID, bit 1 clears ID/EX, bit 2 clears EX/MEM and bit 3 clears MEM/WB. A decode fault gives 0011, an execute fault gives 0111 and a memory fault gives 1111. With no fault, drain or redirect under way, all flush bits are 0.
- R4: redirect is high for exactly the one cycle after the fault cycle, with redirect_pc = 0x40000040 in that cycle.
- R5: Fault requests during the redirect cycle are ignored: epc and cause keep their values, only flush bit 0 is set, and no second redirect follows.
- R6: An interrupt request from idle starts a drain from the next cycle on. During the drain, fetch_hold and flush bit 0 are high. In the first drain cycle where pipe_busy is low, the trap is taken: the next cycle has redirect high, cause = 3 and epc = pc_if.
- R7: A fault reported by an in-flight instruction during a drain is taken at once and abandons the drain. If the interrupt is still requested, the drain restarts after the redirect.
- R8: On a fault, cause takes the code supplied by the winning stage. The codes are 1 for overflow, 2 for page fault and 3 for external interrupt, each field being 2 bits.
- R9: Flush bit 0 is high in the redirect cycle, so the instruction fetched before the redirect never enters decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 3 | Fault request per stage (bit0 decode, bit1 execute, bit2 memory) |
| exc_code | input | 6 | Fault code per stage, 2 bits each, decode in the low field |
| pc_if | input | 32 | PC of the instruction in fetch |
| pc_id | input | 32 | PC of the instruction in decode |
| pc_ex | input | 32 | PC of the instruction in execute |
| pc_mem | input | 32 | PC of the instruction in memory |
| irq | input | 1 | External interrupt request (level) |
| pipe_busy | input | 1 | A valid instruction is still in decode through write-back |
| flush | output | 4 | Clear control of IF/ID, ID/EX, EX/MEM, MEM/WB (bit 0 to 3) |
| fetch_hold | output | 1 | Freeze the PC and fetch |
| redirect | output | 1 | Load redirect_pc into the PC |
| redirect_pc | output | 32 | Handler address while redirect is high, else 0 |
| epc | output | 32 | Saved exception PC |
| cause | output | 2 | Saved cause code |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- the flush bits are nested, so a squash never skips a younger stage;
- a fault cycle is always followed by a redirect, and each redirect lasts one cycle;
- epc and cause hold still across the redirect cycle;
- a drain always freezes fetch without redirecting.

Two things only the bench scenarios can show:
- which stage wins and which PC and code end up in the registers, checked over every combination of simultaneous requests;
- the timing of drains of several lengths, and a fault cutting into a drain followed by a retaken interrupt.

// File: rtl/trap_flush_ctrl.sv
module trap_flush_ctrl #(
  parameter int XLEN = 32,
  parameter int CW = 2,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h4000_0040
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      exc_req,
  input  logic [3*CW-1:0] exc_code,
  input  logic [XLEN-1:0] pc_if,
  input  logic [XLEN-1:0] pc_id,
  input  logic [XLEN-1:0] pc_ex,
  input  logic [XLEN-1:0] pc_mem,
  input  logic            irq,
  input  logic            pipe_busy,
  output logic [3:0]      flush,
  output logic            fetch_hold,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] epc,
  output logic [CW-1:0]   cause
);
  localparam logic [CW-1:0] CAUSE_IRQ = CW'(3);

  typedef enum logic [1:0] {S_RUN, S_DRAIN, S_REDIR} st_t;
  st_t st, st_nx;

  logic            take, irq_done;
  logic [1:0]      win;
  logic [XLEN-1:0] win_pc;
  logic [CW-1:0]   win_code;

  assign take     = (st != S_REDIR) && |exc_req;
  assign irq_done = (st == S_DRAIN) && !pipe_busy && !take;

  always_comb begin
    if (exc_req[2])      begin win = 2'd2; win_pc = pc_mem; end
    else if (exc_req[1]) begin win = 2'd1; win_pc = pc_ex;  end
    else                 begin win = 2'd0; win_pc = pc_id;  end
  end
  assign win_code = exc_code[win*CW +: CW];

  assign flush[0] = take || (st == S_DRAIN) || (st == S_REDIR);
  assign flush[1] = take;
  assign flush[2] = take && (win != 2'd0);
  assign flush[3] = take && (win == 2'd2);

  assign fetch_hold  = (st == S_DRAIN);
  assign redirect    = (st == S_REDIR);
  assign redirect_pc = redirect ? HANDLER_PC : '0;

  always_comb begin
    st_nx = st;
    if (take || irq_done)          st_nx = S_REDIR;
    else if (st == S_REDIR)        st_nx = S_RUN;
    else if (st == S_RUN && irq)   st_nx = S_DRAIN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_RUN;
      epc   <= '0;
      cause <= '0;
    end else begin
      st <= st_nx;
      if (take) begin
        epc   <= win_pc;
        cause <= win_code;
      end else if (irq_done) begin
        epc   <= pc_if;
        cause <= CAUSE_IRQ;
      end
    end
  end
endmodule

// File: rtl/trap_flush_ctrl_chk.sv
module trap_flush_ctrl_chk #(
  parameter int XLEN = 32,
  parameter int CW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      exc_req,
  input logic [3:0]      flush,
  input logic            fetch_hold,
  input logic            redirect,
  input logic [XLEN-1:0] epc,
  input logic [CW-1:0]   cause
);
  // R3
  flush_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush[3] |-> flush[2]) and (flush[2] |-> flush[1]) and (flush[1] |-> flush[0]));

  // R3
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req == 3'b000 && !fetch_hold && !redirect) |-> flush == 4'b0000);

  // R4
  redir_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req != 3'b000 && !redirect) |=> redirect);

  // R4
  redir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);

  // R5
  redir_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> ($stable(epc) && $stable(cause)));

  // R9
  redir_flush_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (flush[0] && flush[3:1] == 3'b000));

  // R6
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hold |-> (flush[0] && !redirect));
endmodule

bind trap_flush_ctrl trap_flush_ctrl_chk #(.XLEN(XLEN), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .flush(flush),
  .fetch_hold(fetch_hold), .redirect(redirect), .epc(epc), .cause(cause));

// File: tb/test_trap_flush_ctrl.sv
module test_trap_flush_ctrl;
  localparam logic [31:0] HANDLER = 32'h4000_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  exc_req = '0;
  logic [5:0]  exc_code = '0;
  logic [31:0] pc_if = '0, pc_id = '0, pc_ex = '0, pc_mem = '0;
  logic        irq = 1'b0, pipe_busy = 1'b0;
  logic [3:0]  flush;
  logic        fetch_hold, redirect;
  logic [31:0] redirect_pc, epc;
  logic [1:0]  cause;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  trap_flush_ctrl i_trap_flush_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .pc_if(pc_if), .pc_id(pc_id), .pc_ex(pc_ex), .pc_mem(pc_mem),
    .irq(irq), .pipe_busy(pipe_busy), .flush(flush), .fetch_hold(fetch_hold),
    .redirect(redirect), .redirect_pc(redirect_pc), .epc(epc), .cause(cause));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] exp_epc;
    logic [1:0]  exp_cause;

    repeat (2) step();
    #1;
    chk("R1 flush", 32'(flush), 0);
    chk("R1 hold", 32'(fetch_hold), 0);
    chk("R1 redirect", 32'(redirect), 0);
    chk("R1 epc", epc, 0);
    chk("R1 cause", 32'(cause), 0);
    step(); rst_n = 1'b1;

    for (int p = 1; p < 8; p++) begin
      logic [1:0] c0, c1, c2;
      int w;
      c0 = 2'((p % 2) + 1);
      c1 = 2'(((p + 1) % 2) + 1);
      c2 = 2'(((p + 2) % 2) + 1);
      w  = p[2] ? 2 : (p[1] ? 1 : 0);
      step();
      exc_req  = 3'(p);
      exc_code = {c2, c1, c0};
      pc_if = 32'h100 * p; pc_id = pc_if + 32'h10;
      pc_ex = pc_if + 32'h20; pc_mem = pc_if + 32'h30;
      exp_epc   = (w == 2) ? pc_mem : (w == 1) ? pc_ex : pc_id;
      exp_cause = (w == 2) ? c2 : (w == 1) ? c1 : c0;
      #1;
      chk("R3 flush pattern", 32'(flush), (32'd1 << (w + 2)) - 1);
      chk("R4 no early redirect", 32'(redirect), 0);
      step();
      exc_req = 3'b111;
      exc_code = 6'b111111;
      pc_id = 32'hdead_0000; pc_ex = 32'hdead_0004; pc_mem = 32'hdead_0008;
      #1;
      chk("R4 redirect", 32'(redirect), 1);
      chk("R4 handler pc", redirect_pc, HANDLER);
      chk("R2 epc winner", epc, exp_epc);
      chk("R8 cause winner", 32'(cause), 32'(exp_cause));
      chk("R9 flush in redirect", 32'(flush), 1);
      step();
      exc_req = '0;
      #1;
      chk("R4 single redirect", 32'(redirect), 0);
      chk("R5 epc kept", epc, exp_epc);
      chk("R5 cause kept", 32'(cause), 32'(exp_cause));
      chk("R3 quiet flush", 32'(flush), 0);
    end

    for (int n = 0; n < 4; n++) begin
      step();
      irq = 1'b1; pipe_busy = 1'b1;
      pc_if = 32'h2000 + 32'(n * 4);
      #1;
      chk("R6 no hold yet", 32'(fetch_hold), 0);
      for (int k = 0; k < n; k++) begin
        step(); #1;
        chk("R6 hold busy", 32'(fetch_hold), 1);
        chk("R6 flush busy", 32'(flush), 1);
        chk("R6 wait", 32'(redirect), 0);
      end
      step();
      pipe_busy = 1'b0;
      #1;
      chk("R6 hold last", 32'(fetch_hold), 1);
      step();
      irq = 1'b0;
      #1;
      chk("R6 redirect", 32'(redirect), 1);
      chk("R6 cause", 32'(cause), 3);
      chk("R6 epc", epc, 32'h2000 + 32'(n * 4));
      step(); #1;
      chk("R6 released", 32'(fetch_hold) | 32'(redirect), 0);
    end

    step();
    irq = 1'b1; pipe_busy = 1'b1; pc_if = 32'h5000;
    step();
    exc_req = 3'b010; exc_code = 6'b000100; pc_ex = 32'h3000;
    #1;
    chk("R7 flush during drain", 32'(flush), 7);
    step();
    exc_req = '0;
    #1;
    chk("R7 redirect", 32'(redirect), 1);
    chk("R7 epc", epc, 32'h3000);
    chk("R7 cause", 32'(cause), 1);
    step(); #1;
    chk("R7 drain abandoned", 32'(fetch_hold), 0);
    step();
    pipe_busy = 1'b0;
    #1;
    chk("R7 drain restarted", 32'(fetch_hold), 1);
    step();
    irq = 1'b0;
    #1;
    chk("R7 irq taken", 32'(cause), 3);
    chk("R7 irq epc", epc, 32'h5000);

    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule